// File: doc/BRIEF.md
# Accumulator Store Rounding and Write-Back Path

This block turns a 40-bit signed accumulator (8 guard bits, then a 1.31 fraction) into a 16-bit 1.15 word ready to be stored. The word can be taken by plain truncation, by round-half-up, or by round-half-to-even. After rounding, an optional saturation stage clamps any result that no longer fits the 1.15 range. The rounding and saturation datapath is purely combinational.

Two accumulators feed the block. A plain store converts the accumulator that the operation names. A multiply-accumulate write-back converts the other accumulator, and it always rounds.

The block also steers the result. It goes either into a working register directly or into memory at the address that register holds. In the second case the pointer then advances by one word (2 bytes). The updated register value is registered. It changes only on cycles that carry a store.

Top module: `acc_store_path`

## Requirements
- R1: With no rounding in effect (`rnd_req`=0 and `mac_wb`=0), `wr_data` equals accumulator bits 31..16 when saturation is off, and the low 16 bits are ignored.
- R2: In half-up mode (`rnd_even`=0), with rounding in effect, the high word (bits 39..16) is incremented exactly when accumulator bit 15 is 1.
- R3: In half-to-even mode (`rnd_even`=1), the result matches R2 except when bits 15..0 equal 0x8000. In that case the high word is incremented only if accumulator bit 16 is 1.
- R4: With `mac_wb`=1, rounding is applied whatever the value of `rnd_req`, and the non-target accumulator is converted. With `mac_wb`=0, the target accumulator is converted. `tgt_b`=0 names accumulator A and `tgt_b`=1 names accumulator B.
- R5: With `sat_en`=1, the rounded 25-bit signed high value (guard bits plus rounding carry) is checked against the 1.15 range. Values above 0x7FFF output 0x7FFF, values below -0x8000 output 0x8000, and values in range pass through unchanged.
- R6: With `sat_en`=0, `wr_data` is the low 16 bits of the rounded high value, with no clamping.
- R7: `mem_we` = `st_req` & `dst_ind` and `reg_we` = `st_req` & ~`dst_ind`, both in the same cycle. `wr_addr` equals `ptr_cur`.
- R8: After a clock edge with `st_req`=1 and `dst_ind`=1, `ptr_upd` equals the sampled `ptr_cur` + 2.
- R9: After a clock edge with `st_req`=1 and `dst_ind`=0, `ptr_upd` equals the `wr_data` of that cycle.
- R10: After a clock edge with `st_req`=0, `ptr_upd` is unchanged.
- R11: Synchronous reset clears `ptr_upd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_req | input | 1 | A store happens this cycle |
| mac_wb | input | 1 | Store is a multiply-accumulate write-back |
| tgt_b | input | 1 | Target accumulator: 0 = A, 1 = B |
| acc_a | input | 40 | Accumulator A |
| acc_b | input | 40 | Accumulator B |
| rnd_req | input | 1 | Round on a plain store |
| rnd_even | input | 1 | 0 = round half up, 1 = round half to even |
| sat_en | input | 1 | Saturate the stored word |
| dst_ind | input | 1 | 0 = write the register, 1 = write memory at the pointer and advance it |
| ptr_cur | input | 16 | Current value of the working register |
| wr_data | output | 16 | 1.15 word to store |
| mem_we | output | 1 | Memory write strobe |
| reg_we | output | 1 | Register write strobe |
| wr_addr | output | 16 | Memory write address |
| ptr_upd | output | 16 | Registered new value of the working register |

## Verification
The bench targets exact 0x8000 low words with both parities of bit 16. A design that ignores the tie rule will drift from half-to-even to half-up, or will break ties the wrong way. It drives 0x7FFF high words that round into a carry. A design that saturates before rounding, or that checks only 16 bits, will then emit 0x8000 in place of 0x7FFF. Guard-bit overflow with a zero high word is checked both with and without saturation, to catch a clamp that misses the guard bits. Write-back cases use different A and B values with `rnd_req` low, which exposes a wrong accumulator choice or a missed forced rounding. Store-free cycles follow stores, to show that the pointer holds.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
    localparam int ACC_W  = 40;
    localparam int DATA_W = 16;
    localparam int HI_W   = ACC_W - DATA_W;
    localparam int EXT_W  = HI_W + 1;

    typedef enum logic {
        RND_HALF_UP   = 1'b0,
        RND_HALF_EVEN = 1'b1
    } rnd_mode_e;

    typedef enum logic {
        DST_REG = 1'b0,
        DST_MEM = 1'b1
    } dst_mode_e;

    typedef struct packed {
        logic [EXT_W-1:0] val;
        logic             inc;
    } rnd_word_t;

    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic logic want_inc(input logic [DATA_W-1:0] lo,
                                      input logic hi_lsb,
                                      input rnd_mode_e mode);
        logic above_half;
        above_half = |lo[DATA_W-2:0];
        return lo[DATA_W-1] && ((mode == RND_HALF_UP) || above_half || hi_lsb);
    endfunction
endpackage

// File: rtl/acc_round.sv
module acc_round
    import acc_store_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc,
    input  logic             do_round,
    input  rnd_mode_e        mode,
    output rnd_word_t        res
);
    logic [HI_W-1:0]   hi;
    logic [DATA_W-1:0] lo;
    logic              inc;

    always_comb begin
        hi      = acc[ACC_W-1:DATA_W];
        lo      = acc[DATA_W-1:0];
        inc     = do_round && want_inc(lo, hi[0], mode);
        res.inc = inc;
        res.val = {hi[HI_W-1], hi} + {{(EXT_W-1){1'b0}}, inc};
    end

    assert_inc_needs_half_R2: assert property (@(posedge clk) disable iff (rst)
        res.inc |-> acc[DATA_W-1]);

    assert_even_tie_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == RND_HALF_EVEN && acc[DATA_W-1:0] == NEG_MAX && !acc[DATA_W])
        |-> !res.inc);
endmodule

// File: rtl/acc_sat.sv
module acc_sat
    import acc_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rnd_word_t         res,
    input  logic              sat_en,
    output logic [DATA_W-1:0] q
);
    logic fits;
    logic neg;

    always_comb begin
        neg  = res.val[EXT_W-1];
        fits = (&res.val[EXT_W-1:DATA_W-1]) || !(|res.val[EXT_W-1:DATA_W-1]);
        if (sat_en && !fits)
            q = neg ? NEG_MAX : POS_MAX;
        else
            q = res.val[DATA_W-1:0];
    end

    assert_clamp_R5: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !fits) |-> (q == POS_MAX || q == NEG_MAX));

    assert_clamp_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !fits) |-> (q[DATA_W-1] == res.val[EXT_W-1]));
endmodule

// File: rtl/wb_ptr.sv
module wb_ptr
    import acc_store_pkg::*;
#(
    parameter int AW   = 16,
    parameter int STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_req,
    input  dst_mode_e         dst,
    input  logic [AW-1:0]     ptr_cur,
    input  logic [DATA_W-1:0] data,
    output logic [AW-1:0]     ptr_q
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (st_req)
            ptr_q <= (dst == DST_MEM) ? ptr_cur + STEP_V : AW'(data);
    end

    assert_post_inc_R8: assert property (@(posedge clk) disable iff (rst)
        (st_req && dst == DST_MEM) |=> ptr_q == $past(ptr_cur) + STEP_V);

    assert_direct_R9: assert property (@(posedge clk) disable iff (rst)
        (st_req && dst == DST_REG) |=> ptr_q == AW'($past(data)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !st_req |=> $stable(ptr_q));
endmodule

// File: rtl/acc_store_path.sv
module acc_store_path
    import acc_store_pkg::*;
#(
    parameter int AW       = 16,
    parameter int PTR_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_req,
    input  logic              mac_wb,
    input  logic              tgt_b,
    input  logic [ACC_W-1:0]  acc_a,
    input  logic [ACC_W-1:0]  acc_b,
    input  logic              rnd_req,
    input  logic              rnd_even,
    input  logic              sat_en,
    input  logic              dst_ind,
    input  logic [AW-1:0]     ptr_cur,
    output logic [DATA_W-1:0] wr_data,
    output logic              mem_we,
    output logic              reg_we,
    output logic [AW-1:0]     wr_addr,
    output logic [AW-1:0]     ptr_upd
);
    logic             use_b;
    logic [ACC_W-1:0] acc_sel;
    logic             do_round;
    rnd_word_t        rnd;
    rnd_mode_e        mode;
    dst_mode_e        dst;

    always_comb begin
        use_b    = mac_wb ? !tgt_b : tgt_b;
        acc_sel  = use_b ? acc_b : acc_a;
        do_round = rnd_req || mac_wb;
        mode     = rnd_even ? RND_HALF_EVEN : RND_HALF_UP;
        dst      = dst_ind ? DST_MEM : DST_REG;
        mem_we   = st_req && dst_ind;
        reg_we   = st_req && !dst_ind;
        wr_addr  = ptr_cur;
    end

    acc_round u_round (
        .clk(clk), .rst(rst), .acc(acc_sel), .do_round(do_round),
        .mode(mode), .res(rnd)
    );

    acc_sat u_sat (
        .clk(clk), .rst(rst), .res(rnd), .sat_en(sat_en), .q(wr_data)
    );

    wb_ptr #(.AW(AW), .STEP(PTR_STEP)) u_ptr (
        .clk(clk), .rst(rst), .st_req(st_req), .dst(dst),
        .ptr_cur(ptr_cur), .data(wr_data), .ptr_q(ptr_upd)
    );

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && reg_we));
endmodule

// File: tb/sim_acc_store_path.sv
module sim_acc_store_path;
    logic        clk = 1'b0;
    logic        rst;
    logic        st_req, mac_wb, tgt_b, rnd_req, rnd_even, sat_en, dst_ind;
    logic [39:0] acc_a, acc_b;
    logic [15:0] ptr_cur;
    logic [15:0] wr_data, wr_addr, ptr_upd;
    logic        mem_we, reg_we;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_ptr;
    bit done = 0;

    always #4 clk = ~clk;

    acc_store_path u0 (
        .clk(clk), .rst(rst), .st_req(st_req), .mac_wb(mac_wb), .tgt_b(tgt_b),
        .acc_a(acc_a), .acc_b(acc_b), .rnd_req(rnd_req), .rnd_even(rnd_even),
        .sat_en(sat_en), .dst_ind(dst_ind), .ptr_cur(ptr_cur),
        .wr_data(wr_data), .mem_we(mem_we), .reg_we(reg_we),
        .wr_addr(wr_addr), .ptr_upd(ptr_upd)
    );

    function automatic logic [15:0] ref_data(input logic [39:0] acc, input bit rnd,
                                             input bit even, input bit sat);
        longint hi;
        longint lo;
        bit inc;
        hi = longint'($signed(acc[39:16]));
        lo = longint'(acc[15:0]);
        inc = rnd && (lo > 32768 || (lo == 32768 && (!even || hi[0])));
        hi = hi + longint'(inc);
        if (sat && hi > 32767)  hi = 32767;
        if (sat && hi < -32768) hi = -32768;
        return hi[15:0];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input bit sr, input bit mw, input bit tb_,
                         input logic [39:0] a, input logic [39:0] b, input bit rr,
                         input bit ev, input bit se, input bit di, input logic [15:0] p);
        logic [39:0] src;
        bit          rnd;
        logic [15:0] ed;
        @(negedge clk);
        st_req = sr; mac_wb = mw; tgt_b = tb_; acc_a = a; acc_b = b;
        rnd_req = rr; rnd_even = ev; sat_en = se; dst_ind = di; ptr_cur = p;
        src = (mw ? !tb_ : tb_) ? b : a;
        rnd = rr || mw;
        ed  = ref_data(src, rnd, ev, se);
        #1;
        chk(req, wr_data, ed);
        chk("R7 mem_we", {15'd0, mem_we}, {15'd0, sr && di});
        chk("R7 reg_we", {15'd0, reg_we}, {15'd0, sr && !di});
        chk("R7 wr_addr", wr_addr, p);
        if (sr) exp_ptr = di ? p + 16'd2 : ed;
        @(posedge clk);
        #1;
        chk(sr ? (di ? "R8 ptr post-inc" : "R9 ptr direct") : "R10 ptr hold",
            ptr_upd, exp_ptr);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        rst = 1'b1; st_req = 0; mac_wb = 0; tgt_b = 0; acc_a = '0; acc_b = '0;
        rnd_req = 0; rnd_even = 0; sat_en = 0; dst_ind = 0; ptr_cur = 16'h1234;
        exp_ptr = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset ptr", ptr_upd, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        // R1 truncation ignores low word
        apply("R1 trunc", 1, 0, 0, 40'h00_1234_FFFF, 40'h0, 0, 0, 0, 1, 16'h0100);
        // R2 half up: tie goes up, just below half stays
        apply("R2 halfup tie", 1, 0, 0, 40'h00_0002_8000, 40'h0, 1, 0, 0, 1, 16'h0200);
        apply("R2 halfup below", 1, 0, 0, 40'h00_0002_7FFF, 40'h0, 1, 0, 0, 0, 16'h0);
        // R3 half even ties
        apply("R3 even tie even", 1, 0, 0, 40'h00_0002_8000, 40'h0, 1, 1, 0, 1, 16'h0300);
        apply("R3 even tie odd", 1, 0, 0, 40'h00_0003_8000, 40'h0, 1, 1, 0, 1, 16'h0300);
        apply("R3 even above", 1, 0, 0, 40'h00_0002_8001, 40'h0, 1, 1, 0, 1, 16'h0300);
        // R5 rounding carry into overflow clamps; R6 wraps
        apply("R5 carry clamp", 1, 0, 0, 40'h00_7FFF_8000, 40'h0, 1, 0, 1, 1, 16'h0400);
        apply("R6 carry wrap", 1, 0, 0, 40'h00_7FFF_8000, 40'h0, 1, 0, 0, 1, 16'h0400);
        apply("R5 guard pos", 1, 0, 0, 40'h01_0000_0000, 40'h0, 0, 0, 1, 1, 16'h0400);
        apply("R6 guard wrap", 1, 0, 0, 40'h01_0000_0000, 40'h0, 0, 0, 0, 1, 16'h0400);
        apply("R5 guard neg", 1, 0, 0, 40'hFF_0000_0000, 40'h0, 0, 0, 1, 1, 16'h0400);
        apply("R5 in range neg", 1, 0, 0, 40'hFF_FFFF_8000, 40'h0, 0, 0, 1, 1, 16'h0400);
        // R4 write-back: other accumulator, forced rounding
        apply("R4 wb target A", 1, 1, 0, 40'h00_1111_0000, 40'h00_2222_8000, 0, 0, 0, 0, 16'h0);
        apply("R4 wb target B", 1, 1, 1, 40'h00_1111_C000, 40'h00_2222_0000, 0, 0, 0, 1, 16'h0500);
        apply("R4 plain target B", 1, 0, 1, 40'h00_1111_C000, 40'h00_2222_0000, 0, 0, 0, 1, 16'h0500);
        // R10 no store
        apply("R10 idle", 0, 0, 0, 40'h00_7777_0000, 40'h0, 0, 0, 0, 1, 16'hABCD);
        apply("R10 idle direct", 0, 0, 0, 40'h00_7777_0000, 40'h0, 0, 0, 0, 0, 16'h9999);
        // R8 pointer wrap at top of range
        apply("R8 wrap", 1, 0, 0, 40'h0, 40'h0, 0, 0, 0, 1, 16'hFFFE);

        for (int i = 0; i < 600; i++) begin
            logic [39:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) a[15:0] = 16'h8000;
            if ($urandom_range(0, 3) == 0) b[15:0] = 16'h8000;
            if ($urandom_range(0, 2) == 0) a[39:32] = {8{a[31]}};
            apply("R1-6 random data", $urandom_range(0, 3) != 0, 1'($urandom), 1'($urandom),
                  a, b, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  16'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule